// File: doc/BRIEF.md
# Transport Stream Energy De-dispersal

This block undoes the energy-dispersal randomisation applied to a byte-wide transport stream made of 188-byte packets. A 15-stage pseudo-random generator (polynomial 1 + x^14 + x^15) is restarted from a fixed seed whenever a packet begins with the bit-inverted sync value 0xB8. That value marks the first packet of a group of eight. Every byte that is not a sync byte is XORed with eight generator bits. Sync bytes are never XORed, and each 0xB8 sync is rewritten to the normal value 0x47, so every packet that leaves the block carries the same sync byte.

The input arrives already packet-aligned. A start-of-packet strobe marks the sync positions. Valid, start-of-packet and error-flag sidebands travel with each byte, and all outputs appear a fixed number of clock cycles after the input. An unlocked indication stays high from reset until the first group-start packet reaches the output. Before that point, bytes pass through unchanged.

Top module: `ed_descrambler`

## Requirements
- R1: While reset is high and after reset ends, with no input, `out_valid` is 0 and `unlocked` is 1.
- R2: Before the first group-start sync (start-of-packet byte equal to 0xB8) has been accepted, every byte leaves unchanged, including any 0xB8 seen outside a sync position, and `unlocked` is 1.
- R3: A start-of-packet byte of 0xB8 leaves as 0x47, reloads the generator with seed stages 1..15 = 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0, and from that byte onward `unlocked` is 0.
- R4: After lock, each non-sync byte is XORed with the next eight generator outputs, the first into bit 7. The generator feedback and output are stage14 XOR stage15, shifted into stage 1. With zero payload, the two bytes after a group start are 0x03 and 0xF6.
- R5: After lock, a start-of-packet byte other than 0xB8 leaves unchanged, but the generator still advances eight steps during it.
- R6: A 0xB8 value at a non-start-of-packet position is ordinary data and is descrambled.
- R7: Cycles with `in_valid` low neither advance the generator nor produce an output beat.
- R8: Data, `out_valid`, `out_sop`, `out_err` and `unlocked` all appear exactly LATENCY cycles (default 2) after the input byte is accepted.
- R9: Bytes whose error flag is set are still descrambled, and the flag is reproduced on `out_err`.
- R10: A 0xB8 start-of-packet byte reseeds the generator wherever it falls, even if fewer than eight packets have passed since the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sop | input | 1 | Input byte is a packet's sync position |
| in_err | input | 1 | Input packet error flag |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte qualifier |
| out_sop | output | 1 | Output byte is a sync position |
| out_err | output | 1 | Delayed error flag |
| out_data | output | 8 | Descrambled byte |
| unlocked | output | 1 | High until a group-start sync has been output |

## Verification
A wrong generator state shows up at once. If the seed, taps or bit order is off, the first data byte after a 0xB8 sync is already wrong. A generator that skips or repeats advances, during sync slots or idle cycles, stays correct until the next sync slot or gap and then corrupts every byte after it until the next reseed. A wrong lock state shows up on the first byte: bytes that should pass through get altered, or bytes that should be XORed pass through clean, and `unlocked` disagrees with the expected value on that beat. A miscount in the delay line shifts every beat of every sideband at once.

// File: rtl/ed_pkg.sv
package ed_pkg;
    localparam int BYTE_W   = 8;
    localparam int PRBS_LEN = 15;
    localparam int TAP_LO   = 14;
    localparam int TAP_HI   = 15;

    localparam logic [BYTE_W-1:0] SYNC_NORMAL = 8'h47;
    localparam logic [BYTE_W-1:0] SYNC_GROUP  = 8'hB8;

    // bit k holds stage k+1 of the shift register
    localparam logic [PRBS_LEN-1:0] PRBS_SEED = 15'h00A9;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_GROUP,
        SLOT_SYNC,
        SLOT_DATA
    } slot_e;

    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              err;
        logic              lck;
        logic [BYTE_W-1:0] dat;
    } beat_t;

    function automatic logic [PRBS_LEN-1:0] prbs_step(input logic [PRBS_LEN-1:0] s);
        logic fb;
        fb = s[TAP_LO-1] ^ s[TAP_HI-1];
        return {s[PRBS_LEN-2:0], fb};
    endfunction

    function automatic logic [BYTE_W-1:0] prbs_key(input logic [PRBS_LEN-1:0] s);
        logic [BYTE_W-1:0]   k;
        logic [PRBS_LEN-1:0] w;
        w = s;
        k = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            k[BYTE_W-1-i] = w[TAP_LO-1] ^ w[TAP_HI-1];
            w = prbs_step(w);
        end
        return k;
    endfunction

    function automatic logic [PRBS_LEN-1:0] prbs_advance(input logic [PRBS_LEN-1:0] s);
        logic [PRBS_LEN-1:0] w;
        w = s;
        for (int i = 0; i < BYTE_W; i++) begin
            w = prbs_step(w);
        end
        return w;
    endfunction
endpackage

// File: rtl/ed_slot_class.sv
module ed_slot_class
    import ed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              sop,
    input  logic [BYTE_W-1:0] dat,
    output slot_e             slot,
    output logic              lck
);
    logic locked_q;

    always_comb begin
        if (!vld)                     slot = SLOT_IDLE;
        else if (sop && dat == SYNC_GROUP) slot = SLOT_GROUP;
        else if (sop)                 slot = SLOT_SYNC;
        else                          slot = SLOT_DATA;
    end

    assign lck = locked_q || (slot == SLOT_GROUP);

    always_ff @(posedge clk) begin
        if (rst)                     locked_q <= 1'b0;
        else if (slot == SLOT_GROUP) locked_q <= 1'b1;
    end

    // R3: once lock is taken it is never dropped outside reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);
endmodule

// File: rtl/ed_prbs.sv
module ed_prbs
    import ed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    output logic [BYTE_W-1:0] key
);
    logic [PRBS_LEN-1:0] st_q;

    assign key = prbs_key(st_q);

    always_ff @(posedge clk) begin
        if (rst || load) st_q <= PRBS_SEED;
        else if (adv)    st_q <= prbs_advance(st_q);
    end

    // R4: a maximal-length register seeded non-zero never reaches all zeros
    p_state_live_r4: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);

    // R7: no load and no advance leaves the state untouched
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(st_q));
endmodule

// File: rtl/ed_delay.sv
module ed_delay
    import ed_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d,
    output beat_t q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            beat_t stg_q [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                beat_t src;
                if (i == 0) begin : g_first
                    assign src = d;
                end else begin : g_next
                    assign src = stg_q[i-1];
                end
                always_ff @(posedge clk) begin
                    if (rst) stg_q[i] <= '0;
                    else     stg_q[i] <= src;
                end
                // R8: every stage moves the full beat forward by one cycle
                p_stage_shift_r8: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> (stg_q[i] == $past(src)));
            end
            assign q = stg_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ed_descrambler.sv
module ed_descrambler
    import ed_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_err,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_err,
    output logic [BYTE_W-1:0] out_data,
    output logic              unlocked
);
    localparam int TAIL = (LATENCY > 1) ? LATENCY - 1 : 0;

    slot_e             slot;
    logic              lck;
    logic [BYTE_W-1:0] key;
    logic              gen_load;
    logic              gen_adv;
    beat_t             beat_d;
    beat_t             beat_q;
    beat_t             beat_o;

    ed_slot_class u_class (
        .clk  (clk),
        .rst  (rst),
        .vld  (in_valid),
        .sop  (in_sop),
        .dat  (in_data),
        .slot (slot),
        .lck  (lck)
    );

    assign gen_load = (slot == SLOT_GROUP);
    assign gen_adv  = lck && (slot == SLOT_SYNC || slot == SLOT_DATA);

    ed_prbs u_prbs (
        .clk  (clk),
        .rst  (rst),
        .load (gen_load),
        .adv  (gen_adv),
        .key  (key)
    );

    always_comb begin
        beat_d.vld = in_valid;
        beat_d.sop = in_sop;
        beat_d.err = in_err;
        beat_d.lck = lck;
        unique case (slot)
            SLOT_GROUP: beat_d.dat = SYNC_NORMAL;
            SLOT_DATA:  beat_d.dat = lck ? (in_data ^ key) : in_data;
            default:    beat_d.dat = in_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    ed_delay #(.DEPTH(TAIL)) u_tail (
        .clk (clk),
        .rst (rst),
        .d   (beat_q),
        .q   (beat_o)
    );

    assign out_valid = beat_o.vld;
    assign out_sop   = beat_o.sop;
    assign out_err   = beat_o.err;
    assign out_data  = beat_o.dat;
    assign unlocked  = ~beat_o.lck;

    // R2: unlocked beats carry the input byte untouched
    p_passthru_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
        (beat_q.vld && !beat_q.lck) |-> (beat_q.dat == $past(in_data)));

    // R3: a group-start sync leaves as the normal sync with lock set
    p_group_rewrite_r3: assert property (@(posedge clk) disable iff (rst)
        (beat_q.vld && beat_q.sop && $past(in_data) == SYNC_GROUP)
            |-> (beat_q.dat == SYNC_NORMAL && beat_q.lck));

    // R5: a normal sync byte is never XORed
    p_sync_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (beat_q.vld && beat_q.sop && $past(in_data) == SYNC_NORMAL)
            |-> (beat_q.dat == SYNC_NORMAL));

    // R7: an idle input cycle yields an idle beat
    p_idle_beat_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !beat_q.vld);
endmodule

// File: tb/ed_descrambler_tb_top.sv
module ed_descrambler_tb_top;
    localparam int LAT     = 2;
    localparam int PKT_LEN = 188;
    localparam int WD_MAX  = 60000;

    // {group, err, gap[1:0], kind[1:0], fill[7:0]}
    localparam logic [13:0] PKT_TAB [12] = '{
        14'h2110, 14'h04FF, 14'h125A, 14'h0900, 14'h0333, 14'h20C3,
        14'h0E81, 14'h157E, 14'h0000, 14'h01E0, 14'h0047, 14'h3B21
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_err = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_sop, out_err, unlocked;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int grp_seen = 0;

    bit   mdl_lock = 1'b0;
    bit   ms [1:15];

    logic [7:0] q_dat [$];
    bit         q_sop [$];
    bit         q_err [$];
    bit         q_unl [$];
    int         q_cyc [$];
    string      q_tag [$];

    ed_descrambler #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_err(in_err), .in_data(in_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_err(out_err), .out_data(out_data),
        .unlocked(unlocked)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic mdl_key(output logic [7:0] k);
        bit fb;
        k = 8'h00;
        for (int i = 0; i < 8; i++) begin
            fb = ms[14] ^ ms[15];
            for (int j = 15; j >= 2; j--) ms[j] = ms[j-1];
            ms[1] = fb;
            k = {k[6:0], fb};
        end
    endtask

    task automatic mdl_seed();
        for (int j = 1; j <= 15; j++) ms[j] = 1'b0;
        ms[1] = 1'b1; ms[4] = 1'b1; ms[6] = 1'b1; ms[8] = 1'b1;
    endtask

    task automatic put(input bit sop, input bit err, input logic [7:0] d,
                       input bit fe, input logic [7:0] fv, input string tag);
        logic [7:0] k;
        logic [7:0] e;
        bit         u;
        if (sop && d == 8'hB8) begin
            mdl_seed();
            mdl_lock = 1'b1;
            e = 8'h47;
        end else if (!mdl_lock) begin
            e = d;
        end else if (sop) begin
            mdl_key(k);
            e = d;
        end else begin
            mdl_key(k);
            e = d ^ k;
        end
        u = !mdl_lock;
        if (fe) e = fv;
        in_valid = 1'b1; in_sop = sop; in_err = err; in_data = d;
        q_dat.push_back(e); q_sop.push_back(sop); q_err.push_back(err);
        q_unl.push_back(u); q_cyc.push_back(cyc); q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_dat.size() == 0) begin
                chk(1'b0, "R7", "unexpected out_valid", 1, 0);
            end else begin
                automatic logic [7:0] e_d = q_dat.pop_front();
                automatic bit    e_s = q_sop.pop_front();
                automatic bit    e_e = q_err.pop_front();
                automatic bit    e_u = q_unl.pop_front();
                automatic int    e_c = q_cyc.pop_front();
                automatic string tg  = q_tag.pop_front();
                chk(out_data == e_d, tg, "out_data", out_data, e_d);
                chk(out_sop == e_s && out_err == e_e, (e_e ? "R9" : tg),
                    "sop/err", {out_sop, out_err}, {e_s, e_e});
                chk(unlocked == e_u, (e_u ? "R2" : "R3"), "unlocked", unlocked, e_u);
                chk(cyc == e_c + LAT, "R8", "latency", cyc - e_c, LAT);
            end
        end
    end

    task automatic send_pkt(input logic [13:0] ent);
        bit         grp  = ent[13];
        bit         err  = ent[12];
        int         gap  = ent[11:10];
        int         kind = ent[9:8];
        logic [7:0] fill = ent[7:0];
        logic [7:0] b;
        string      tg;
        if (grp) begin
            tg = (grp_seen > 0) ? "R10" : "R3";
            grp_seen++;
            put(1'b1, err, 8'hB8, 1'b0, 8'h00, tg);
        end else begin
            put(1'b1, err, 8'h47, 1'b0, 8'h00, "R5");
        end
        for (int i = 1; i < PKT_LEN; i++) begin
            case (kind)
                0:       b = fill;
                1:       b = fill + 8'(i);
                2:       b = fill ^ 8'(i * 37);
                default: b = (i == 5) ? 8'hB8 : fill;
            endcase
            tg = (kind == 3 && i == 5) ? "R6" : (err ? "R9" : "R4");
            if (gap != 0 && (i % (gap * 5)) == 2) begin
                idle(1);
                tg = "R7";
            end
            put(1'b0, err, b, 1'b0, 8'h00, tg);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > WD_MAX) begin
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, WD_MAX);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(unlocked == 1'b1, "R1", "unlocked in reset", unlocked, 1);
        rst = 1'b0;
        idle(3);
        chk(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);
        chk(unlocked == 1'b1, "R1", "unlocked idle", unlocked, 1);

        // R2: pass-through before lock, stray 0xB8 in data untouched
        put(1'b1, 1'b0, 8'h47, 1'b0, 8'h00, "R2");
        for (int i = 1; i < 20; i++)
            put(1'b0, 1'b0, (i == 7) ? 8'hB8 : 8'(i * 11), 1'b0, 8'h00, "R2");
        idle(2);

        // R3/R4: group start with zero payload, literal key bytes
        put(1'b1, 1'b0, 8'hB8, 1'b1, 8'h47, "R3");
        grp_seen++;
        put(1'b0, 1'b0, 8'h00, 1'b1, 8'h03, "R4");
        put(1'b0, 1'b0, 8'h00, 1'b1, 8'hF6, "R4");
        for (int i = 3; i < PKT_LEN; i++) put(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R4");

        // table of packets: R4 R5 R6 R7 R9 R10
        for (int p = 0; p < 12; p++) send_pkt(PKT_TAB[p]);

        idle(LAT + 4);
        chk(q_dat.size() == 0, "R8", "beats missing", q_dat.size(), 0);
        chk(out_valid == 1'b0, "R7", "out_valid after idle", out_valid, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule